// File: doc/BRIEF.md
# Strobed Output Handshake Port

This block is one byte-wide output channel that a processor writes and an external peripheral drains. A processor write stores the byte in an output register that drives the peripheral pins. The same write pulls an active-low buffer-full line low to tell the peripheral that a fresh byte is waiting. The peripheral answers with an active-low acknowledge pulse. The falling edge of that pulse releases buffer-full. The return of acknowledge to high can raise an interrupt request, which tells the processor that the byte has been taken and the next one may be written.

The interrupt is qualified by an enable bit inside the block. No data write touches this bit. It is changed only by a single-bit set/reset command, which carries a bit select and a value. One select value is chosen by parameter: 6 for a channel on the first port side, 2 for one on the second. The acknowledge pin is asynchronous to the block clock, so it passes through a two-flop synchroniser before its edges are detected. The reset input is asserted asynchronously and released synchronously inside the block.

Top module: `strobed_out_port`

## Requirements
- R1: While reset is active and after its release, `port_out` is 0x00, `obf_n` is 1, `irq` is 0 and the interrupt enable bit is 0.
- R2: A cycle with `wr_stb` high stores `wr_data`. At the next clock edge `port_out` shows that byte and `obf_n` goes low.
- R3: `port_out` keeps its value in every cycle without `wr_stb`, whatever `ack_n` and the command inputs do.
- R4: When `ack_n` is driven from high to low, `obf_n` returns to 1 at the third rising clock edge after `ack_n` is sampled low: two synchroniser stages plus one edge-detect register.
- R5: When `ack_n` returns from low to high, a pending interrupt is recorded at the third rising clock edge after `ack_n` is sampled high, provided the enable bit was 1 before that edge. `irq` then reads 1.
- R6: A command cycle (`cmd_stb` high) with `cmd_sel` equal to the enable select (default 6) loads `cmd_val` into the enable bit. A command with any other `cmd_sel` value leaves the enable bit and `irq` unchanged.
- R7: `irq` equals the pending interrupt ANDed with the enable bit. Clearing the enable bit drops `irq` at the next edge. Setting it again shows a pending interrupt that has not been cleared.
- R8: A processor write clears the pending interrupt, so `irq` is 0 after the write's clock edge.
- R9: If a write and an acknowledge edge act on the same clock edge, the write wins. `obf_n` is 0 after that edge, and no interrupt is recorded on that edge.
- R10: An acknowledge return while the enable bit is 0 records nothing. Setting the enable bit later does not raise `irq`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_stb | input | 1 | One-cycle processor write strobe |
| wr_data | input | 8 | Byte to latch onto the port |
| cmd_stb | input | 1 | One-cycle single-bit set/reset command strobe |
| cmd_sel | input | 3 | Bit select of the set/reset command |
| cmd_val | input | 1 | Value written by the set/reset command |
| ack_n | input | 1 | Asynchronous active-low acknowledge from the peripheral |
| port_out | output | 8 | Latched output byte to the peripheral |
| obf_n | output | 1 | Active-low output-buffer-full to the peripheral |
| irq | output | 1 | Interrupt request to the processor |

## Verification
A processor write and a synchronised acknowledge edge can land on the same clock edge. The write asks for buffer-full low and clears the interrupt. The edge asks for buffer-full high or sets the interrupt. The bench times its write strobe so that the write lands on exactly the edge where a delayed acknowledge fall or rise is acted on. It counts the three-register latency of the acknowledge path to place that edge. It then judges the result against a cycle-by-cycle reference model, where the write must win: `obf_n` stays low and `irq` stays low.

// File: rtl/strobed_port_pkg.sv
package strobed_port_pkg;

  // Edge events recovered from the synchronised acknowledge line
  typedef struct packed {
    logic fall;   // acknowledge asserted (high to low)
    logic rise;   // acknowledge released (low to high)
  } ack_evt_t;

endpackage

// File: rtl/sop_rst_sync.sv
module sop_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_o = chain_q[STAGES-1];

endmodule

// File: rtl/sop_ack_sync.sv
module sop_ack_sync
  import strobed_port_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     ack_n_i,
  output ack_evt_t evt_o
);

  localparam int TOP = STAGES - 1;

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              last_q;
  logic              last_d;

  // Shift the raw pin in; remember the previous synchronised level
  always_comb begin
    sync_d = {sync_q[STAGES-2:0], ack_n_i};
    last_d = sync_q[TOP];
  end

  // Idle acknowledge level is high, so reset to ones to avoid a false edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      last_q <= 1'b1;
    end else begin
      sync_q <= sync_d;
      last_q <= last_d;
    end
  end

  always_comb begin
    evt_o.fall = last_q & ~sync_q[TOP];
    evt_o.rise = ~last_q & sync_q[TOP];
  end

endmodule

// File: rtl/sop_hs_ctrl.sv
module sop_hs_ctrl
  import strobed_port_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  ack_evt_t          evt,
  output logic [DATA_W-1:0] port_out,
  output logic              obf_n
);

  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] data_d;
  logic              data_en;
  logic              obf_q;
  logic              obf_d;

  // Next state: a write takes priority over an acknowledge fall
  always_comb begin
    data_en = wr_stb;
    data_d  = wr_data;
    obf_d   = obf_q;
    if (wr_stb) begin
      obf_d = 1'b0;
    end else if (evt.fall) begin
      obf_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (data_en) begin
      data_q <= data_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      obf_q <= 1'b1;
    end else begin
      obf_q <= obf_d;
    end
  end

  assign port_out = data_q;
  assign obf_n    = obf_q;

endmodule

// File: rtl/sop_irq_ctrl.sv
module sop_irq_ctrl
  import strobed_port_pkg::*;
#(
  parameter int SEL_W  = 3,
  parameter int EN_SEL = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_stb,
  input  logic             cmd_stb,
  input  logic [SEL_W-1:0] cmd_sel,
  input  logic             cmd_val,
  input  ack_evt_t         evt,
  output logic             irq,
  output logic             en_o
);

  localparam logic [SEL_W-1:0] EN_SEL_V = SEL_W'(EN_SEL);

  logic en_q;
  logic en_d;
  logic en_ld;
  logic pend_q;
  logic pend_d;

  always_comb begin
    en_ld = cmd_stb && (cmd_sel == EN_SEL_V);
    en_d  = cmd_val;
  end

  // A write clears the request and outranks an acknowledge rise
  always_comb begin
    pend_d = pend_q;
    if (wr_stb) begin
      pend_d = 1'b0;
    end else if (evt.rise && en_q) begin
      pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
    end else if (en_ld) begin
      en_q <= en_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
    end
  end

  assign irq  = pend_q & en_q;
  assign en_o = en_q;

endmodule

// File: rtl/strobed_out_port.sv
module strobed_out_port
  import strobed_port_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SEL_W       = 3,
  parameter int EN_SEL      = 6,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              cmd_stb,
  input  logic [SEL_W-1:0]  cmd_sel,
  input  logic              cmd_val,
  input  logic              ack_n,
  output logic [DATA_W-1:0] port_out,
  output logic              obf_n,
  output logic              irq
);

  logic     rst_n_int;
  ack_evt_t ack_evt;
  logic     en_int;

  sop_rst_sync #(
    .STAGES (RST_STAGES)
  ) u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_n_int)
  );

  sop_ack_sync #(
    .STAGES (SYNC_STAGES)
  ) u_ack (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .ack_n_i (ack_n),
    .evt_o   (ack_evt)
  );

  sop_hs_ctrl #(
    .DATA_W (DATA_W)
  ) u_hs (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .wr_stb   (wr_stb),
    .wr_data  (wr_data),
    .evt      (ack_evt),
    .port_out (port_out),
    .obf_n    (obf_n)
  );

  sop_irq_ctrl #(
    .SEL_W  (SEL_W),
    .EN_SEL (EN_SEL)
  ) u_irq (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .wr_stb  (wr_stb),
    .cmd_stb (cmd_stb),
    .cmd_sel (cmd_sel),
    .cmd_val (cmd_val),
    .evt     (ack_evt),
    .irq     (irq),
    .en_o    (en_int)
  );

endmodule

// File: rtl/sop_checker.sv
module sop_checker #(
  parameter int DATA_W = 8,
  parameter int SEL_W  = 3,
  parameter int EN_SEL = 6
) (
  input logic              clk,
  input logic              rst_ni,
  input logic              wr_stb,
  input logic [DATA_W-1:0] wr_data,
  input logic              cmd_stb,
  input logic [SEL_W-1:0]  cmd_sel,
  input logic              cmd_val,
  input logic [DATA_W-1:0] port_out,
  input logic              obf_n,
  input logic              irq,
  input logic              en
);

  localparam logic [SEL_W-1:0] EN_SEL_V = SEL_W'(EN_SEL);

  p_write_obf_low_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    wr_stb |=> !obf_n);

  p_write_data_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    wr_stb |=> (port_out == $past(wr_data)));

  p_data_hold_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    !wr_stb |=> $stable(port_out));

  p_obf_release_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(obf_n) |-> !$past(wr_stb));

  p_en_load_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    (cmd_stb && cmd_sel == EN_SEL_V) |=> (en == $past(cmd_val)));

  p_en_ignore_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    !(cmd_stb && cmd_sel == EN_SEL_V) |=> $stable(en));

  p_irq_gated_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    $fell(en) |-> !irq);

  p_write_clears_irq_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    wr_stb |=> !irq);

endmodule

bind strobed_out_port sop_checker #(
  .DATA_W (DATA_W),
  .SEL_W  (SEL_W),
  .EN_SEL (EN_SEL)
) u_chk (
  .clk      (clk),
  .rst_ni   (rst_n_int),
  .wr_stb   (wr_stb),
  .wr_data  (wr_data),
  .cmd_stb  (cmd_stb),
  .cmd_sel  (cmd_sel),
  .cmd_val  (cmd_val),
  .port_out (port_out),
  .obf_n    (obf_n),
  .irq      (irq),
  .en       (en_int)
);

// File: tb/sim_strobed_out_port.sv
`timescale 1ns/1ps
module sim_strobed_out_port;

  logic       clk;
  logic       rst_n;
  logic       wr_stb;
  logic [7:0] wr_data;
  logic       cmd_stb;
  logic [2:0] cmd_sel;
  logic       cmd_val;
  logic       ack_n;
  logic [7:0] port_out;
  logic       obf_n;
  logic       irq;

  strobed_out_port u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_stb   (wr_stb),
    .wr_data  (wr_data),
    .cmd_stb  (cmd_stb),
    .cmd_sel  (cmd_sel),
    .cmd_val  (cmd_val),
    .ack_n    (ack_n),
    .port_out (port_out),
    .obf_n    (obf_n),
    .irq      (irq)
  );

  int    n_checks;
  int    n_fail;
  bit    cmp_on;
  bit    done;
  string cur_req;

  // Reference model state
  logic [7:0] m_data;
  bit         m_obf;
  bit         m_pend;
  bit         m_en;
  bit         ack_hist [3];   // [0] newest sample ... [2] oldest
  int         rel_cnt;

  initial begin
    clk = 1'b0;
    forever #2.5 clk = ~clk;
  end

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_data = 8'h00;
    m_obf  = 1'b1;
    m_pend = 1'b0;
    m_en   = 1'b0;
    for (int i = 0; i < 3; i++) ack_hist[i] = 1'b1;
  endtask

  // Behavioural reference: acknowledge seen three edges late, write has priority
  always @(posedge clk) begin
    bit fall_ev;
    bit rise_ev;
    bit en_next;
    if (!rst_n) begin
      rel_cnt = 0;
      model_reset();
    end else if (rel_cnt < 2) begin
      rel_cnt++;
    end else begin
      fall_ev = ack_hist[2] && !ack_hist[1];
      rise_ev = !ack_hist[2] && ack_hist[1];
      en_next = (cmd_stb && cmd_sel == 3'd6) ? cmd_val : m_en;
      if (wr_stb) begin
        m_data = wr_data;
        m_obf  = 1'b0;
        m_pend = 1'b0;
      end else begin
        if (fall_ev) m_obf = 1'b1;
        if (rise_ev && m_en) m_pend = 1'b1;
      end
      m_en = en_next;
      ack_hist[2] = ack_hist[1];
      ack_hist[1] = ack_hist[0];
      ack_hist[0] = ack_n;
    end
  end

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (cmp_on) begin
      check(cur_req, "port_out", 32'(port_out), 32'(m_data));
      check(cur_req, "obf_n",    32'(obf_n),    32'(m_obf));
      check(cur_req, "irq",      32'(irq),      32'(m_pend && m_en));
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_write(input logic [7:0] d);
    wr_stb  = 1'b1;
    wr_data = d;
    tick(1);
    wr_stb  = 1'b0;
  endtask

  task automatic do_cmd(input logic [2:0] sel, input logic val);
    cmd_stb = 1'b1;
    cmd_sel = sel;
    cmd_val = val;
    tick(1);
    cmd_stb = 1'b0;
  endtask

  task automatic ack_pulse(input int low_cycles);
    ack_n = 1'b0;
    tick(low_cycles);
    ack_n = 1'b1;
  endtask

  initial begin
    n_checks = 0;
    n_fail   = 0;
    cmp_on   = 1'b0;
    done     = 1'b0;
    cur_req  = "R1";
    rel_cnt  = 0;
    model_reset();
    rst_n   = 1'b0;
    wr_stb  = 1'b0;
    wr_data = 8'h00;
    cmd_stb = 1'b0;
    cmd_sel = 3'd0;
    cmd_val = 1'b0;
    ack_n   = 1'b1;

    tick(1);
    cmp_on = 1'b1;
    // R1: values during reset
    check("R1", "port_out in reset", 32'(port_out), 32'h00);
    check("R1", "obf_n in reset",    32'(obf_n),    32'h1);
    check("R1", "irq in reset",      32'(irq),      32'h0);
    tick(3);
    rst_n = 1'b1;
    tick(4);
    check("R1", "obf_n after release", 32'(obf_n), 32'h1);
    check("R1", "irq after release",   32'(irq),   32'h0);

    // R2: write latches and lowers buffer-full
    cur_req = "R2";
    do_write(8'hA5);
    check("R2", "port_out after write", 32'(port_out), 32'hA5);
    check("R2", "obf_n after write",    32'(obf_n),    32'h0);

    // R4: acknowledge fall releases buffer-full on the third edge
    cur_req = "R4";
    ack_n = 1'b0;
    tick(2);
    check("R4", "obf_n two edges after ack", 32'(obf_n), 32'h0);
    tick(1);
    check("R4", "obf_n three edges after ack", 32'(obf_n), 32'h1);
    // R3: data held across acknowledge and commands
    cur_req = "R3";
    tick(2);
    ack_n = 1'b1;
    do_cmd(3'd1, 1'b1);
    tick(4);
    check("R3", "port_out held", 32'(port_out), 32'hA5);
    // R10: return with enable clear records nothing
    cur_req = "R10";
    do_cmd(3'd6, 1'b1);
    tick(2);
    check("R10", "irq after late enable", 32'(irq), 32'h0);

    // R5: enabled acknowledge return raises irq on the third edge
    cur_req = "R5";
    do_write(8'h3C);
    ack_pulse(3);
    tick(2);
    check("R5", "irq two edges after return", 32'(irq), 32'h0);
    tick(1);
    check("R5", "irq three edges after return", 32'(irq), 32'h1);

    // R6: other selects ignored, including the other side's bit
    cur_req = "R6";
    do_cmd(3'd2, 1'b0);
    do_cmd(3'd7, 1'b0);
    check("R6", "irq after foreign commands", 32'(irq), 32'h1);
    // R7: mask and unmask
    cur_req = "R7";
    do_cmd(3'd6, 1'b0);
    check("R7", "irq masked", 32'(irq), 32'h0);
    do_cmd(3'd6, 1'b1);
    check("R7", "irq unmasked", 32'(irq), 32'h1);

    // R8: write clears the request
    cur_req = "R8";
    do_write(8'h5A);
    check("R8", "irq after write", 32'(irq), 32'h0);
    check("R8", "port_out after write", 32'(port_out), 32'h5A);

    // R9: write on the same edge as the acknowledge fall
    cur_req = "R9";
    ack_n = 1'b0;
    tick(2);
    do_write(8'hC3);
    check("R9", "obf_n write vs fall", 32'(obf_n), 32'h0);
    tick(3);
    check("R9", "obf_n stays low", 32'(obf_n), 32'h0);
    // R9: write on the same edge as the acknowledge rise
    ack_n = 1'b1;
    tick(2);
    do_write(8'h96);
    check("R9", "irq write vs rise", 32'(irq), 32'h0);
    tick(3);
    check("R9", "irq stays low", 32'(irq), 32'h0);
    check("R9", "port_out last write", 32'(port_out), 32'h96);

    // Back-to-back traffic with varied pulse widths
    cur_req = "R2";
    for (int k = 0; k < 6; k++) begin
      do_write(8'(8'h11 * (k + 1)));
      tick(k % 3);
      ack_pulse(1 + (k % 4));
      tick(4);
    end

    // R1: reset in mid-traffic restores idle values
    cur_req = "R1";
    rst_n = 1'b0;
    tick(2);
    check("R1", "port_out re-reset", 32'(port_out), 32'h00);
    check("R1", "irq re-reset", 32'(irq), 32'h0);
    rst_n = 1'b1;
    tick(5);

    cmp_on = 1'b0;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog %s actual=hung expected=done", cur_req);
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

endmodule